// File: doc/BRIEF.md
# Selectable-Mode Serial Frame Check Unit

This block computes a 16-bit cyclic redundancy check one bit at a time for both directions of a multi-protocol serial link. The transmit lane accumulates outgoing data bits and then drains its register as the check field. The receive lane accumulates incoming data bits and the check field that follows them, and raises a good-frame flag when the register holds the expected end value.

A two-bit error-control mode input sets three things together: the generator polynomial, the value loaded by the start strobe, and whether the drained check field is complemented. One engine therefore covers bit-oriented framing (all-ones preset, complemented field, fixed non-zero residue) and byte-oriented framing (all-zeros preset, true remainder, zero residue). The check field is sent as two successive bytes. Framing, bit stuffing and character assembly are handled elsewhere. The feeder presents data bits in the order they go on the line, which is least significant bit first within each character.

Top module: `crc_frame_unit`

## Requirements
- R1: After reset both lane registers hold zero. So in mode 0, `tx_ser` is 1 and `rx_ok` is 0. In modes 1 to 3, `tx_ser` is 0 and `rx_ok` is 1.
- R2: The mode codes are:
  - Mode 0: polynomial 0x1021, preset 0xFFFF, complemented check field, good residue 0x1D0F.
  - Mode 1: polynomial 0x8005, preset 0x0000, true field, residue 0x0000.
  - Mode 2: polynomial 0x1021, preset 0x0000, true field, residue 0x0000.
  - Mode 3: behaves exactly as mode 2.
- R3: A lane preset strobe loads that mode's preset value at the next clock edge. It takes priority over a bit enable in the same cycle.
- R4: On an enabled data cycle, the register shifts toward its most significant end. The feedback is register bit 15 XOR the data bit, and the polynomial is XORed in when the feedback is 1.
- R5: On a transmit cycle with `tx_bit_en` and `tx_drain` both high, `tx_ser` shows register bit 15, complemented in mode 0, before the edge. The register then shifts left with zero fill. After 16 such cycles `tx_ser` equals the mode's complement setting.
- R6: A lane register does not change on a cycle where its bit enable and its preset are both low. This holds whatever the data and drain inputs are.
- R7: `rx_ok` is 1 when the receive register equals the mode's residue. A frame followed by its correct check field, most significant bit first, leaves `rx_ok` at 1.
- R8: The lanes are independent. Strobes and data on one lane do not change the other lane's output.
- R9: A frame with any single bit flipped, in the data or in the check field, leaves `rx_ok` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecm_mode | input | 2 | Error-control mode select |
| tx_preset | input | 1 | Load preset into transmit register |
| tx_bit_en | input | 1 | Transmit bit cycle enable |
| tx_data | input | 1 | Transmit data bit |
| tx_drain | input | 1 | Transmit check-field output request |
| tx_ser | output | 1 | Serial check-field bit |
| rx_preset | input | 1 | Load preset into receive register |
| rx_bit_en | input | 1 | Receive bit cycle enable |
| rx_data | input | 1 | Received bit, data or check field |
| rx_ok | output | 1 | Receive register equals the good residue |

## Verification
The hardest case to reach from the ports is a receive register holding exactly the mode's residue. That value only arises when a frame is closed by the correct check field, computed under the same mode. The bench loops the transmit lane straight into the receive lane in the same cycle, so every drained check bit is accumulated as it appears. It sweeps all modes, several frame lengths and patterns, idle gaps, and preset-with-enable collisions. It then flips each single bit position in turn to show that the residue is missed.

// File: rtl/crc_frame_pkg.sv
package crc_frame_pkg;
    localparam int CRC_W = 16;

    typedef enum logic [1:0] {
        ECM_BIT_CCITT  = 2'd0,
        ECM_BYTE_CRC16 = 2'd1,
        ECM_BYTE_CCITT = 2'd2,
        ECM_BYTE_ALT   = 2'd3
    } ecm_e;

    typedef struct packed {
        logic [CRC_W-1:0] poly;
        logic [CRC_W-1:0] init;
        logic             inv;
        logic [CRC_W-1:0] residue;
    } crc_cfg_t;
endpackage

// File: rtl/crc_mode_decode.sv
module crc_mode_decode
    import crc_frame_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY_CCITT  = 16'h1021,
    parameter logic [CRC_W-1:0] POLY_C16    = 16'h8005,
    parameter logic [CRC_W-1:0] RESIDUE_INV = 16'h1D0F
) (
    input  logic [1:0] ecm_mode,
    output crc_cfg_t   cfg
);
    localparam logic [CRC_W-1:0] ALL_ONES  = '1;
    localparam logic [CRC_W-1:0] ALL_ZEROS = '0;

    always_comb begin
        case (ecm_e'(ecm_mode))
            ECM_BIT_CCITT: begin
                cfg.poly    = POLY_CCITT;
                cfg.init    = ALL_ONES;
                cfg.inv     = 1'b1;
                cfg.residue = RESIDUE_INV;
            end
            ECM_BYTE_CRC16: begin
                cfg.poly    = POLY_C16;
                cfg.init    = ALL_ZEROS;
                cfg.inv     = 1'b0;
                cfg.residue = ALL_ZEROS;
            end
            default: begin
                cfg.poly    = POLY_CCITT;
                cfg.init    = ALL_ZEROS;
                cfg.inv     = 1'b0;
                cfg.residue = ALL_ZEROS;
            end
        endcase
    end
endmodule

// File: rtl/crc_lane.sv
module crc_lane #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] poly,
    input  logic [W-1:0] init,
    input  logic         preset,
    input  logic         bit_en,
    input  logic         din,
    input  logic         drain,
    output logic [W-1:0] crc
);
    typedef struct packed {
        logic [W-1:0] crc;
    } lane_st_t;

    lane_st_t     st_d, st_q;
    logic         fb;
    logic [W-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        fb      = st_q.crc[W-1] ^ din;
        shifted = {st_q.crc[W-2:0], 1'b0};
        if (preset) begin
            st_d.crc = init;
        end else if (bit_en) begin
            if (drain) begin
                st_d.crc = shifted;
            end else begin
                st_d.crc = shifted ^ (fb ? poly : '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc = st_q.crc;
endmodule

// File: rtl/crc_frame_unit.sv
module crc_frame_unit
    import crc_frame_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY_CCITT  = 16'h1021,
    parameter logic [CRC_W-1:0] POLY_C16    = 16'h8005,
    parameter logic [CRC_W-1:0] RESIDUE_INV = 16'h1D0F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ecm_mode,
    input  logic       tx_preset,
    input  logic       tx_bit_en,
    input  logic       tx_data,
    input  logic       tx_drain,
    output logic       tx_ser,
    input  logic       rx_preset,
    input  logic       rx_bit_en,
    input  logic       rx_data,
    output logic       rx_ok
);
    localparam int MSB = CRC_W - 1;

    crc_cfg_t         cfg;
    logic [CRC_W-1:0] tx_crc;
    logic [CRC_W-1:0] rx_crc;
    logic             unused_tx_low;

    crc_mode_decode #(
        .POLY_CCITT (POLY_CCITT),
        .POLY_C16   (POLY_C16),
        .RESIDUE_INV(RESIDUE_INV)
    ) u_decode (
        .ecm_mode(ecm_mode),
        .cfg     (cfg)
    );

    crc_lane #(.W(CRC_W)) u_tx_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .poly  (cfg.poly),
        .init  (cfg.init),
        .preset(tx_preset),
        .bit_en(tx_bit_en),
        .din   (tx_data),
        .drain (tx_drain),
        .crc   (tx_crc)
    );

    crc_lane #(.W(CRC_W)) u_rx_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .poly  (cfg.poly),
        .init  (cfg.init),
        .preset(rx_preset),
        .bit_en(rx_bit_en),
        .din   (rx_data),
        .drain (1'b0),
        .crc   (rx_crc)
    );

    assign tx_ser        = tx_crc[MSB] ^ cfg.inv;
    assign rx_ok         = (rx_crc == cfg.residue);
    assign unused_tx_low = ^tx_crc[MSB-1:0];
endmodule

// File: rtl/crc_frame_unit_chk.sv
module crc_frame_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  ecm_mode,
    input logic        tx_preset,
    input logic        tx_bit_en,
    input logic        tx_drain,
    input logic        rx_preset,
    input logic        rx_bit_en,
    input logic        tx_ser,
    input logic        rx_ok,
    input logic [15:0] tx_crc,
    input logic [15:0] rx_crc
);
    // R3: the preset value wins over a same-cycle enable
    a_r3_preset_loads: assert property (@(posedge clk) disable iff (!rst_n)
        tx_preset |=> (tx_crc == (($past(ecm_mode) == 2'd0) ? 16'hFFFF : 16'h0000)));

    // R3, R2: mode 0 preset gives a complemented top bit of 0
    a_r3_bit_preset_out: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_preset && ecm_mode == 2'd0) |=> (ecm_mode != 2'd0 || tx_ser == 1'b0));

    // R5: drain shifts left with zero fill
    a_r5_drain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_preset && tx_bit_en && tx_drain) |=> (tx_crc == {$past(tx_crc[14:0]), 1'b0}));

    // R6: idle cycles hold both registers
    a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_preset && !tx_bit_en) |=> $stable(tx_crc));
    a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_preset && !rx_bit_en) |=> $stable(rx_crc));

    // R7: a byte-mode receive preset reads as good at once
    a_r7_byte_preset_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_preset && ecm_mode != 2'd0) |=> (ecm_mode == 2'd0 || rx_ok));

    // R8: an idle receive lane keeps its flag under a fixed mode
    a_r8_rx_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_preset && !rx_bit_en) |=> ($stable(rx_ok) || !$stable(ecm_mode)));
endmodule

bind crc_frame_unit crc_frame_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ecm_mode (ecm_mode),
    .tx_preset(tx_preset),
    .tx_bit_en(tx_bit_en),
    .tx_drain (tx_drain),
    .rx_preset(rx_preset),
    .rx_bit_en(rx_bit_en),
    .tx_ser   (tx_ser),
    .rx_ok    (rx_ok),
    .tx_crc   (tx_crc),
    .rx_crc   (rx_crc)
);

// File: tb/crc_frame_unit_bench.sv
module crc_frame_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ecm_mode = 2'd0;
    logic       tx_preset = 1'b0, tx_bit_en = 1'b0, tx_data = 1'b0, tx_drain = 1'b0;
    logic       rx_preset = 1'b0, rx_bit_en = 1'b0, rx_data = 1'b0;
    logic       tx_ser, rx_ok;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    crc_frame_unit u_crc_frame_unit (
        .clk(clk), .rst_n(rst_n), .ecm_mode(ecm_mode),
        .tx_preset(tx_preset), .tx_bit_en(tx_bit_en), .tx_data(tx_data),
        .tx_drain(tx_drain), .tx_ser(tx_ser),
        .rx_preset(rx_preset), .rx_bit_en(rx_bit_en), .rx_data(rx_data),
        .rx_ok(rx_ok)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [15:0] m_poly(input logic [1:0] m);
        return (m == 2'd1) ? 16'h8005 : 16'h1021;
    endfunction

    function automatic logic [15:0] m_init(input logic [1:0] m);
        return (m == 2'd0) ? 16'hFFFF : 16'h0000;
    endfunction

    function automatic logic [15:0] m_mask(input logic [1:0] m);
        return (m == 2'd0) ? 16'hFFFF : 16'h0000;
    endfunction

    function automatic logic [15:0] m_step(input logic [15:0] c, input logic b, input logic [15:0] p);
        logic [15:0] s;
        s = {c[14:0], 1'b0};
        return (c[15] ^ b) ? (s ^ p) : s;
    endfunction

    function automatic logic pat(input int seed, input int i);
        logic [31:0] v;
        v = seed * 31 + i * 17 + (i * i) % 7;
        return v[0] ^ v[3];
    endfunction

    task automatic idle_all();
        tx_preset = 0; tx_bit_en = 0; tx_drain = 0; tx_data = 0;
        rx_preset = 0; rx_bit_en = 0; rx_data = 0;
    endtask

    // Transmit frame looped into the receiver; gaps insert idle cycles, collide adds enable to the preset cycle
    task automatic run_frame(input logic [1:0] m, input int len, input int seed, input bit gaps, input bit collide);
        logic [15:0] model, got, expf;
        logic        b;
        ecm_mode = m;
        tx_preset = 1; rx_preset = 1;
        tx_bit_en = collide; rx_bit_en = collide; tx_data = 1; rx_data = 1;
        step();
        idle_all();
        model = m_init(m);
        for (int i = 0; i < len; i++) begin
            b = pat(seed, i);
            tx_data = b; rx_data = b; tx_bit_en = 1; rx_bit_en = 1;
            model = m_step(model, b, m_poly(m));
            step();
            if (gaps) begin
                tx_bit_en = 0; rx_bit_en = 0; tx_drain = 1;
                tx_data = ~b; rx_data = ~b;
                step();
                tx_drain = 0;
            end
        end
        expf = model ^ m_mask(m);
        got = '0;
        for (int i = 0; i < 16; i++) begin
            tx_bit_en = 1; tx_drain = 1;
            b = tx_ser;
            got = {got[14:0], b};
            rx_data = b; rx_bit_en = 1;
            step();
            if (gaps) begin
                tx_bit_en = 0; rx_bit_en = 0;
                rx_data = ~b; tx_data = ~b;
                step();
            end
        end
        idle_all();
        chk(got == expf, collide ? "R3 field" : (gaps ? "R6 field" : "R2 R4 R5 field"), {16'h0, got}, {16'h0, expf});
        chk(rx_ok == 1'b1, "R7 good frame", {31'h0, rx_ok}, 32'h1);
        chk(tx_ser == (m == 2'd0), "R5 cleared after drain", {31'h0, tx_ser}, {31'h0, (m == 2'd0)});
    endtask

    // Receive-only frame with one bit flipped
    task automatic err_frame(input logic [1:0] m, input int seed, input int pos);
        logic [15:0] model, fld;
        logic [23:0] bits;
        ecm_mode = m;
        rx_preset = 1;
        step();
        idle_all();
        model = m_init(m);
        for (int i = 0; i < 8; i++) begin
            bits[i] = pat(seed, i);
            model = m_step(model, bits[i], m_poly(m));
        end
        fld = model ^ m_mask(m);
        for (int i = 0; i < 16; i++) bits[8 + i] = fld[15 - i];
        bits[pos] = ~bits[pos];
        for (int i = 0; i < 24; i++) begin
            rx_data = bits[i]; rx_bit_en = 1;
            step();
        end
        idle_all();
        chk(rx_ok == 1'b0, "R9 single-bit error", {31'h0, rx_ok}, 32'h0);
    endtask

    // Receive activity in the middle of a transmit frame
    task automatic iso_frame(input logic [1:0] m, input int seed);
        logic [15:0] model, got, expf;
        logic        okv;
        ecm_mode = m;
        tx_preset = 1;
        step();
        idle_all();
        model = m_init(m);
        for (int i = 0; i < 8; i++) begin
            tx_data = pat(seed, i); tx_bit_en = 1;
            model = m_step(model, pat(seed, i), m_poly(m));
            step();
        end
        idle_all();
        rx_preset = 1; step(); idle_all();
        for (int i = 0; i < 10; i++) begin
            rx_data = pat(seed + 3, i); rx_bit_en = 1; step();
        end
        idle_all();
        okv = rx_ok;
        expf = model ^ m_mask(m);
        got = '0;
        for (int i = 0; i < 16; i++) begin
            tx_bit_en = 1; tx_drain = 1;
            got = {got[14:0], tx_ser};
            step();
        end
        idle_all();
        chk(got == expf, "R8 tx unaffected by rx", {16'h0, got}, {16'h0, expf});
        chk(rx_ok == okv, "R8 rx unaffected by tx", {31'h0, rx_ok}, {31'h0, okv});
        tx_preset = 1; step(); idle_all();
        chk(rx_ok == okv, "R8 rx unaffected by tx preset", {31'h0, rx_ok}, {31'h0, okv});
    endtask

    initial begin
        int lens[8] = '{0, 1, 2, 7, 8, 16, 17, 32};
        step();
        // R1: reset state, viewed under two modes
        chk(tx_ser == 1'b1, "R1 reset tx_ser mode0", {31'h0, tx_ser}, 32'h1);
        chk(rx_ok == 1'b0, "R1 reset rx_ok mode0", {31'h0, rx_ok}, 32'h0);
        ecm_mode = 2'd1;
        #1;
        chk(tx_ser == 1'b0, "R1 reset tx_ser mode1", {31'h0, tx_ser}, 32'h0);
        chk(rx_ok == 1'b1, "R1 reset rx_ok mode1", {31'h0, rx_ok}, 32'h1);
        rst_n = 1;
        step();
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 8; l++) begin
                for (int s = 0; s < 3; s++) run_frame(m[1:0], lens[l], s * 5 + l, 1'b0, 1'b0);
            end
            run_frame(m[1:0], 9, 11, 1'b1, 1'b0);
            run_frame(m[1:0], 0, 0, 1'b0, 1'b1);
            run_frame(m[1:0], 8, 4, 1'b0, 1'b1);
            for (int p = 0; p < 24; p++) err_frame(m[1:0], p + 2, p);
            iso_frame(m[1:0], 6 + m);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule